// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

The block holds two or four independent 32-bit down-counters. A simple memory-mapped write/read port programs them. Each channel sits in its own 32-byte address window. The channel number is the address bits above bit 4.

Each channel has a control word that sets the following:
- whether the channel counts at all;
- whether it counts 16 or 32 bits;
- whether it stops, reloads or wraps once it has counted down;
- a tick prescaler;
- whether its interrupt line is driven.

The counter is fed by one of two tick sources, a slow one and a fast one, which arrive as single-cycle enable pulses. Software can load the count at once, or it can stage only the value used at the next reload. It reads the raw and the masked event flags and clears the event by writing the clear register.

Top module: `tmr_bank`

## Requirements
- R1: After reset each channel reads control 0x20, value 0x0000FFFF, load 0xFFFFFFFF, and raw and masked status 0. Every interrupt line is low.
- R2: A write to the load register (offset 0x00) sets the count and the reload value. The value register (0x04) shows the new count in the next cycle.
- R3: A write to the background load register (0x18) changes only the reload value. Reading 0x00 or 0x18 returns the reload value, and the count is left as it was.
- R4: The count drops by one on each qualifying tick only while the enable bit (control bit 7) is set. A disabled channel keeps its count.
- R5: Control bit 9 set makes the fast tick drive the channel and clear makes the slow tick drive it. Pulses on the unselected source have no effect.
- R6: Control bits [3:2] pick the prescaler: 00 and 11 count every tick, 01 counts every 16th tick, 10 counts every 256th tick. The tick count restarts at each control write.
- R7: A tick that takes the count from 1 to 0 sets the raw flag (0x10 bit 0). With periodic mode (bit 6) set, the next tick at zero loads the reload value.
- R8: With bits 6 and 0 clear, a tick at zero wraps the count to 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode (bit 1 set).
- R9: With one-shot (bit 0) set, the count stops at zero and further ticks leave it there. This takes precedence over periodic mode.
- R10: With bit 1 clear, only the low 16 bits of the count take part, and the value register reads them with the upper half zero.
- R11: The masked status (0x14) and the channel's interrupt line equal the raw flag ANDed with control bit 5.
- R12: Any write to the clear register (0x0C) drops the raw flag. If a zero-reaching tick lands in the same cycle, the flag stays set.
- R13: Channels are independent. Offset 0x1C and windows above the channel count read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address: window index above bit 4, register in bits [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| slow_tick | input | 1 | Single-cycle pulse of the slow tick source |
| fast_tick | input | 1 | Single-cycle pulse of the fast tick source |
| irq | output | NCH | Per-channel interrupt line |

## Verification
The properties assume the following about the inputs:
- Tick inputs are clean single-cycle pulses.
- A write addresses exactly one register in one cycle.
- Hold and stop checks apply only in cycles without a load or control write to that channel.

The directed stimulus keeps within these assumptions:
- It issues one bus write at a time, each lasting one cycle.
- It spaces every tick pulse a full cycle apart.
- It deliberately overlaps a clear write with a zero-reaching tick only in the collision scenario, which the set-wins rule covers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DW        = 32;
    localparam int WIN_SHIFT = 5;
    localparam int PRE_W     = 8;
    localparam int LOW_W     = 16;

    typedef enum logic [2:0] {
        REG_LOAD  = 3'd0,
        REG_VALUE = 3'd1,
        REG_CTRL  = 3'd2,
        REG_ICLR  = 3'd3,
        REG_RAW   = 3'd4,
        REG_MSK   = 3'd5,
        REG_BGLD  = 3'd6,
        REG_NONE  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV16  = 2'b01,
        PRE_DIV256 = 2'b10,
        PRE_RSVD   = 2'b11
    } pre_e;

    // field order matches the control word bit positions
    typedef struct packed {
        logic fast;
        logic rsv8;
        logic en;
        logic periodic;
        logic ie;
        logic rsv4;
        pre_e pre;
        logic wide;
        logic oneshot;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{fast: 1'b0, rsv8: 1'b0, en: 1'b0,
                                   periodic: 1'b0, ie: 1'b1, rsv4: 1'b0,
                                   pre: PRE_DIV1, wide: 1'b0, oneshot: 1'b0};

    typedef struct packed {
        logic          wr_load;
        logic          wr_ctrl;
        logic          wr_iclr;
        logic          wr_bgld;
        logic [DW-1:0] data;
    } chan_wr_t;

    function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
        ctrl_t c;
        c      = ctrl_t'(w[CTRL_W-1:0]);
        c.rsv8 = 1'b0;
        c.rsv4 = 1'b0;
        return c;
    endfunction

    function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
        return {{(DW-CTRL_W){1'b0}}, c};
    endfunction

    function automatic logic [DW-1:0] width_mask(input logic wide);
        return wide ? {DW{1'b1}} : {{(DW-LOW_W){1'b0}}, {LOW_W{1'b1}}};
    endfunction

    function automatic reg_sel_e sel_from_offset(input logic [2:0] word);
        case (word)
            3'd0:    return REG_LOAD;
            3'd1:    return REG_VALUE;
            3'd2:    return REG_CTRL;
            3'd3:    return REG_ICLR;
            3'd4:    return REG_RAW;
            3'd5:    return REG_MSK;
            3'd6:    return REG_BGLD;
            default: return REG_NONE;
        endcase
    endfunction

    function automatic logic tick_due(input pre_e p, input logic [PRE_W-1:0] cnt);
        case (p)
            PRE_DIV16:  return &cnt[3:0];
            PRE_DIV256: return &cnt;
            default:    return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 7,
    localparam int IDX_W = ADDR_W - WIN_SHIFT
) (
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    output chan_wr_t [NCH-1:0]   wr_v,
    output reg_sel_e             sel,
    output logic [IDX_W-1:0]     idx,
    output logic                 hit
);

    assign idx = addr[ADDR_W-1:WIN_SHIFT];
    assign hit = (int'(idx) < NCH);
    assign sel = sel_from_offset(addr[WIN_SHIFT-1:2]);

    for (genvar g = 0; g < NCH; g++) begin : g_wr
        logic mine;
        assign mine            = wr && hit && (idx == IDX_W'(g));
        assign wr_v[g].wr_load = mine && (sel == REG_LOAD);
        assign wr_v[g].wr_ctrl = mine && (sel == REG_CTRL);
        assign wr_v[g].wr_iclr = mine && (sel == REG_ICLR);
        assign wr_v[g].wr_bgld = mine && (sel == REG_BGLD);
        assign wr_v[g].data    = wdata;
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic src_tick,
    input  pre_e pre,
    output logic tick_out
);

    logic [PRE_W-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pcnt <= '0;
        end else if (src_tick) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign tick_out = src_tick && tick_due(pre, pcnt);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  chan_wr_t      wr,
    input  logic          slow_tick,
    input  logic          fast_tick,
    input  reg_sel_e      rsel,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          raw_o,
    output logic          ie_o,
    output logic          en_o,
    output logic          oneshot_o,
    output logic          zero_evt,
    output logic [DW-1:0] cnt_vis
);

    ctrl_t         ctrl_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] rld_q;
    logic          raw_q;

    logic          src_sel;
    logic          tick;
    logic [DW-1:0] mask;
    logic [DW-1:0] cnt_m;
    logic          at_zero;
    logic          step;
    logic [DW-1:0] cnt_nxt;

    assign src_sel = ctrl_q.fast ? fast_tick : slow_tick;

    tmr_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .clear    (!ctrl_q.en || wr.wr_ctrl),
        .src_tick (src_sel && ctrl_q.en),
        .pre      (ctrl_q.pre),
        .tick_out (tick)
    );

    assign mask     = width_mask(ctrl_q.wide);
    assign cnt_m    = cnt_q & mask;
    assign at_zero  = (cnt_m == '0);
    assign step     = tick && !(ctrl_q.oneshot && at_zero);
    assign zero_evt = step && (cnt_m == DW'(1));

    always_comb begin
        if (at_zero && ctrl_q.periodic && !ctrl_q.oneshot) begin
            cnt_nxt = rld_q & mask;
        end else begin
            cnt_nxt = (cnt_m - 1'b1) & mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            cnt_q  <= '1;
            rld_q  <= '1;
        end else begin
            if (wr.wr_ctrl) begin
                ctrl_q <= ctrl_from_word(wr.data);
            end
            if (wr.wr_load) begin
                cnt_q <= wr.data;
                rld_q <= wr.data;
            end else begin
                if (wr.wr_bgld) begin
                    rld_q <= wr.data;
                end
                if (step) begin
                    cnt_q <= cnt_nxt;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
        end else if (zero_evt) begin
            raw_q <= 1'b1;
        end else if (wr.wr_iclr) begin
            raw_q <= 1'b0;
        end
    end

    always_comb begin
        case (rsel)
            REG_LOAD:  rdata = rld_q;
            REG_VALUE: rdata = cnt_m;
            REG_CTRL:  rdata = ctrl_to_word(ctrl_q);
            REG_RAW:   rdata = {{(DW-1){1'b0}}, raw_q};
            REG_MSK:   rdata = {{(DW-1){1'b0}}, raw_q && ctrl_q.ie};
            REG_BGLD:  rdata = rld_q;
            default:   rdata = '0;
        endcase
    end

    assign irq       = raw_q && ctrl_q.ie;
    assign raw_o     = raw_q;
    assign ie_o      = ctrl_q.ie;
    assign en_o      = ctrl_q.en;
    assign oneshot_o = ctrl_q.oneshot;
    assign cnt_vis   = cnt_m;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              slow_tick,
    input  logic              fast_tick,
    output logic [NCH-1:0]    irq
);

    localparam int IDX_W = ADDR_W - WIN_SHIFT;

    chan_wr_t [NCH-1:0]          wr_v;
    reg_sel_e                    sel;
    logic [IDX_W-1:0]            idx;
    logic                        hit;
    logic [NCH-1:0][DW-1:0]      ch_rd;
    logic [NCH-1:0][DW-1:0]      cnt_v;
    logic [NCH-1:0]              raw_v;
    logic [NCH-1:0]              ie_v;
    logic [NCH-1:0]              en_v;
    logic [NCH-1:0]              os_v;
    logic [NCH-1:0]              evt_v;

    tmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wr_v  (wr_v),
        .sel   (sel),
        .idx   (idx),
        .hit   (hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr_v[g]),
            .slow_tick (slow_tick),
            .fast_tick (fast_tick),
            .rsel      (sel),
            .rdata     (ch_rd[g]),
            .irq       (irq[g]),
            .raw_o     (raw_v[g]),
            .ie_o      (ie_v[g]),
            .en_o      (en_v[g]),
            .oneshot_o (os_v[g]),
            .zero_evt  (evt_v[g]),
            .cnt_vis   (cnt_v[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit && (idx == IDX_W'(i))) begin
                bus_rdata = ch_rd[i];
            end
        end
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 7
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         raw_v,
    input logic [NCH-1:0]         en_v,
    input logic [NCH-1:0]         os_v,
    input logic [NCH-1:0]         evt_v,
    input logic [NCH-1:0][31:0]   cnt_v
);

    localparam int IDX_W = ADDR_W - 5;

    AST_RST_QUIET: assert property (@(posedge clk) rst |=> (raw_v == '0)); // R1

    for (genvar g = 0; g < NCH; g++) begin : g_p
        logic win, w_ld, w_ct, w_cl;
        assign win  = bus_wr && (bus_addr[ADDR_W-1:5] == IDX_W'(g));
        assign w_ld = win && (bus_addr[4:2] == 3'd0);
        assign w_ct = win && (bus_addr[4:2] == 3'd2);
        assign w_cl = win && (bus_addr[4:2] == 3'd3);

        AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
            (!en_v[g] && !w_ld && !w_ct) |=> $stable(cnt_v[g])); // R4

        AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
            evt_v[g] |=> raw_v[g]); // R7

        AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
            (en_v[g] && os_v[g] && (cnt_v[g] == 32'd0) && !w_ld && !w_ct)
            |=> (cnt_v[g] == 32'd0)); // R9

        AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> raw_v[g]); // R11

        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (w_cl && !evt_v[g]) |=> !raw_v[g]); // R12
    end

endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .raw_v    (raw_v),
    .en_v     (en_v),
    .os_v     (os_v),
    .evt_v    (evt_v),
    .cnt_v    (cnt_v)
);

// File: tb/tmr_bank_test.sv
module tmr_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int ADDR_W     = 7;

    localparam logic [4:0] O_LOAD = 5'h00;
    localparam logic [4:0] O_VAL  = 5'h04;
    localparam logic [4:0] O_CTRL = 5'h08;
    localparam logic [4:0] O_ICLR = 5'h0C;
    localparam logic [4:0] O_RAW  = 5'h10;
    localparam logic [4:0] O_MSK  = 5'h14;
    localparam logic [4:0] O_BG   = 5'h18;
    localparam logic [4:0] O_GAP  = 5'h1C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              slow_tick = 1'b0;
    logic              fast_tick = 1'b0;
    logic [NCH-1:0]    irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    tmr_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = {ch, off};
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] ch, input logic [4:0] off, output logic [31:0] d);
        bus_addr = {ch, off};
        #1;
        d = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [1:0] ch, input logic [4:0] off,
                        input logic [31:0] exp);
        logic [31:0] v;
        rd(ch, off, v);
        chk(req, $sformatf("ch%0d off 0x%02h", ch, off), v, exp);
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        rchk("R1", 0, O_CTRL, 32'h20);
        rchk("R1", 0, O_VAL,  32'h0000FFFF);
        rchk("R1", 0, O_LOAD, 32'hFFFFFFFF);
        rchk("R1", 3, O_RAW,  32'h0);
        rchk("R1", 3, O_MSK,  32'h0);
        chk("R1", "irq", {28'd0, irq}, 32'h0);
    endtask

    task automatic t_loads;
        wr(0, O_LOAD, 32'd5);
        rchk("R2", 0, O_VAL,  32'd5);
        rchk("R2", 0, O_LOAD, 32'd5);
        wr(0, O_BG, 32'd9);
        rchk("R3", 0, O_VAL,  32'd5);
        rchk("R3", 0, O_LOAD, 32'd9);
        rchk("R3", 0, O_BG,   32'd9);
    endtask

    task automatic t_periodic;
        wr(0, O_LOAD, 32'd3);
        wr(0, O_CTRL, 32'hE2);
        slow(1);
        rchk("R4", 0, O_VAL, 32'd2);
        fast(1);
        rchk("R5", 0, O_VAL, 32'd2);
        slow(2);
        rchk("R7", 0, O_VAL, 32'd0);
        rchk("R7", 0, O_RAW, 32'd1);
        rchk("R11", 0, O_MSK, 32'd1);
        chk("R11", "irq0", {31'd0, irq[0]}, 32'd1);
        slow(1);
        rchk("R7", 0, O_VAL, 32'd3);
        rchk("R13", 1, O_VAL, 32'h0000FFFF);
        wr(0, O_ICLR, 32'h0);
        rchk("R12", 0, O_RAW, 32'd0);
        chk("R12", "irq0", {31'd0, irq[0]}, 32'd0);
        wr(0, O_CTRL, 32'h20);
        slow(2);
        rchk("R4", 0, O_VAL, 32'd3);
    endtask

    task automatic t_source_mask;
        wr(1, O_LOAD, 32'd10);
        wr(1, O_CTRL, 32'h2A0);
        fast(1);
        rchk("R5", 1, O_VAL, 32'd9);
        slow(2);
        rchk("R5", 1, O_VAL, 32'd9);
        wr(1, O_LOAD, 32'd1);
        wr(1, O_CTRL, 32'h280);
        fast(1);
        rchk("R11", 1, O_VAL, 32'd0);
        rchk("R11", 1, O_RAW, 32'd1);
        rchk("R11", 1, O_MSK, 32'd0);
        chk("R11", "irq1 masked", {31'd0, irq[1]}, 32'd0);
        wr(1, O_CTRL, 32'h20);
        rchk("R11", 1, O_MSK, 32'd1);
        chk("R11", "irq1 unmasked", {31'd0, irq[1]}, 32'd1);
        wr(1, O_ICLR, 32'hDEAD);
        rchk("R12", 1, O_RAW, 32'd0);
    endtask

    task automatic t_wrap;
        wr(2, O_LOAD, 32'h00010001);
        wr(2, O_CTRL, 32'h80);
        rchk("R10", 2, O_VAL, 32'h1);
        slow(1);
        rchk("R7", 2, O_RAW, 32'd1);
        slow(1);
        rchk("R8", 2, O_VAL, 32'h0000FFFF);
        wr(2, O_CTRL, 32'h20);
        wr(3, O_LOAD, 32'd0);
        wr(3, O_CTRL, 32'h82);
        slow(1);
        rchk("R8", 3, O_VAL, 32'hFFFFFFFF);
        rchk("R8", 3, O_RAW, 32'd0);
        wr(3, O_CTRL, 32'h20);
    endtask

    task automatic t_oneshot;
        wr(2, O_ICLR, 32'd0);
        wr(2, O_LOAD, 32'd2);
        wr(2, O_CTRL, 32'hC1);
        slow(3);
        rchk("R9", 2, O_VAL, 32'd0);
        rchk("R9", 2, O_RAW, 32'd1);
        slow(2);
        rchk("R9", 2, O_VAL, 32'd0);
        wr(2, O_CTRL, 32'h20);
    endtask

    task automatic t_prescale;
        wr(3, O_CTRL, 32'h86);
        wr(3, O_LOAD, 32'd100);
        slow(15);
        rchk("R6", 3, O_VAL, 32'd100);
        slow(1);
        rchk("R6", 3, O_VAL, 32'd99);
        wr(3, O_CTRL, 32'h8A);
        wr(3, O_LOAD, 32'd100);
        slow(255);
        rchk("R6", 3, O_VAL, 32'd100);
        slow(1);
        rchk("R6", 3, O_VAL, 32'd99);
        wr(3, O_CTRL, 32'h8E);
        wr(3, O_LOAD, 32'd50);
        slow(1);
        rchk("R6", 3, O_VAL, 32'd49);
        wr(3, O_CTRL, 32'h20);
    endtask

    task automatic t_collide;
        wr(0, O_ICLR, 32'd0);
        wr(0, O_LOAD, 32'd1);
        wr(0, O_CTRL, 32'hE0);
        @(negedge clk);
        slow_tick = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = {2'd0, O_ICLR};
        @(negedge clk);
        slow_tick = 1'b0;
        bus_wr    = 1'b0;
        rchk("R12", 0, O_RAW, 32'd1);
        rchk("R12", 0, O_VAL, 32'd0);
        wr(0, O_CTRL, 32'h20);
    endtask

    task automatic t_decode;
        rchk("R13", 0, O_GAP, 32'd0);
        wr(1, O_LOAD, 32'h1234);
        rchk("R13", 1, O_VAL, 32'h1234);
        rchk("R13", 0, O_VAL, 32'd0);
        rchk("R13", 2, O_LOAD, 32'd2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_loads();
        t_periodic();
        t_source_mask();
        t_wrap();
        t_oneshot();
        t_prescale();
        t_collide();
        t_decode();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule